// File: doc/BRIEF.md
# Pin-Limited Address Expansion Sequencer

This block drives a 24-bit memory address using nine pins. Eight of them form a shared byte bus. The ninth is a single control line. On the board, the shared bus goes straight to the low address bits. It also feeds the data inputs of two parts: a transparent latch, which holds address bits 15:8 while the control line is high and keeps them once it drops, and an edge-triggered register, which samples bits 23:16 on the rising edge of the same line.

A client hands over a 24-bit address and a read/write flag through a ready/valid handshake. The block runs the load sequence. The top byte goes on the bus first, then the control line rises, then the middle byte goes on the bus, then the control line falls, then the low byte goes on the bus. After that the block pulses an access strobe, holds the address for a short time, and raises a one-cycle done pulse.

The block remembers which 256-byte page the external parts currently hold. When the next request falls in the same page, it skips the upper-byte reload and only places the low byte before the strobe. Every bus or control step lasts `STEP_CYC` clocks and the strobe lasts `STROBE_CYC` clocks, so setup and hold margins can be set to suit the memory.

Top module: `addr_expand_seq`

## Requirements
- R1: After reset the control line and the strobe are low, done is low and ready is high. The page memory is empty, so the first access always uses the full sequence, even for address 0x000000.
- R2: During the strobe, the external register, the external latch and the shared bus together present the requested address. The register holds bits 23:16, the latch holds bits 15:8 and the bus carries bits 7:0.
- R3: The control line is low when a sequence begins. The bus value does not change in the cycle in which the control line rises or falls.
- R4: A request whose bits 23:8 equal those of the last fully loaded address leaves the control line untouched. Done follows 2*STEP_CYC+STROBE_CYC clocks after the accepting edge.
- R5: A request in a different page, or the first request after reset, runs the full sequence with exactly one rising control edge. Done follows 6*STEP_CYC+STROBE_CYC clocks after the accepting edge.
- R6: The strobe stays high for exactly STROBE_CYC consecutive clocks.
- R7: The bus stays stable and the control line stays low while the strobe is high and in the clock after it falls.
- R8: Ready is high only when the block is idle. A request presented while it is low is ignored and produces no strobe.
- R9: The write output equals the request's flag (1 = write) while the strobe is high. Done is a single-cycle pulse that comes after the strobe has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 24 | Requested address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Block idle, request accepted on this edge when valid |
| done | output | 1 | One-cycle completion pulse |
| abus | output | 8 | Shared address byte bus |
| ale | output | 1 | Combined latch-enable / register clock line |
| strobe | output | 1 | Access strobe |
| write_o | output | 1 | Direction of the current access |

## Verification
The bench builds the block with STEP_CYC=2 and STROBE_CYC=3. With these values, each step, the strobe and the hold phase all last more than one clock. An off-by-one in the step timer, or a mix-up between the step and strobe lengths, therefore changes the measured latencies of 15 and 7 clocks. The behavioural latch and register models rebuild the address from the pins themselves, so any ordering error in the load sequence shows up as a wrong captured address.

// File: rtl/addr_seq_pkg.sv
// Package: shared state encoding for the address expansion sequencer.
// Assumes nothing beyond the sequence order described in the brief.
package addr_seq_pkg;

    // Sequencer phases, in the order a full load visits them
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HI,       // top byte on bus, control low
        ST_CLE_UP,   // top byte on bus, control high (register captured)
        ST_MID,      // middle byte on bus, control high (latch open)
        ST_CLE_DN,   // middle byte on bus, control low (latch frozen)
        ST_LO,       // low byte on bus, setup before strobe
        ST_STROBE,   // access strobe active
        ST_HOLD      // address held after strobe
    } seq_state_t;

endpackage

// File: rtl/page_tracker.sv
// Module: page_tracker
// Remembers the upper address bits held by the external latch and
// register, plus a valid flag cleared at reset. Reports a hit when a
// candidate address lies in the page already loaded.
// Assumes: load is raised only when a full reload is committed.
module page_tracker #(
    parameter int UPPER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [UPPER_W-1:0] upper_in,
    output logic               hit
);

    logic [UPPER_W-1:0] page_q;
    logic               valid_q;

    // Capture the page for a committed full reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q  <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            page_q  <= upper_in;
            valid_q <= 1'b1;
        end
    end

    // Compare the candidate with the held page
    always_comb hit = valid_q && (page_q == upper_in);

endmodule

// File: rtl/step_timer.sv
// Module: step_timer
// Counts clocks spent in the current phase; restart zeroes it.
// Assumes: the owner restarts it on every phase change.
module step_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    // Elapsed-clock counter, saturating at its maximum
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (count != {CNT_W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// Phase controller. Accepts a request when idle, picks the full or the
// same-page path and steps through the phases with per-phase durations.
// Registers the request and raises a one-cycle done after the hold phase.
// Assumes: STEP_CYC >= 1 and STROBE_CYC >= 1.
module seq_fsm
    import addr_seq_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int STEP_CYC   = 1,
    parameter int STROBE_CYC = 1,
    parameter int CNT_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              page_hit,
    input  logic [CNT_W-1:0]  count,
    output logic              accept,
    output logic              restart,
    output seq_state_t        state,
    output logic [ADDR_W-1:0] addr_q,
    output logic              write_q,
    output logic              done
);

    localparam logic [CNT_W-1:0] STEP_LAST   = CNT_W'(STEP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);

    seq_state_t next;
    logic       last;
    logic       done_d;

    // Detect the final clock of the current phase
    always_comb last = (state == ST_STROBE) ? (count == STROBE_LAST)
                                            : (count == STEP_LAST);

    // Next-phase selection
    always_comb begin
        next   = state;
        accept = 1'b0;
        done_d = 1'b0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1;
                next   = page_hit ? ST_LO : ST_HI;
            end
            ST_HI:     if (last) next = ST_CLE_UP;
            ST_CLE_UP: if (last) next = ST_MID;
            ST_MID:    if (last) next = ST_CLE_DN;
            ST_CLE_DN: if (last) next = ST_LO;
            ST_LO:     if (last) next = ST_STROBE;
            ST_STROBE: if (last) next = ST_HOLD;
            ST_HOLD: if (last) begin
                next   = ST_IDLE;
                done_d = 1'b1;
            end
            default: next = ST_IDLE;
        endcase
    end

    always_comb restart = (next != state);

    // Phase register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= next;
            done  <= done_d;
        end
    end

    // Request capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
        end
    end

endmodule

// File: rtl/addr_expand_seq.sv
// Module: addr_expand_seq (top)
// Drives a three-byte address through one shared byte bus and one control
// line feeding an external transparent latch (middle byte) and an
// edge-triggered register (top byte). Skips the upper reload when the
// page is unchanged. Pin values are decoded from the registered phase.
// Assumes: the latch is transparent while the control line is high and the
// register samples on its rising edge.
module addr_expand_seq
    import addr_seq_pkg::*;
#(
    parameter int BUS_W      = 8,
    parameter int STEP_CYC   = 1,
    parameter int STROBE_CYC = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [3*BUS_W-1:0]   req_addr,
    input  logic                 req_write,
    output logic                 req_ready,
    output logic                 done,
    output logic [BUS_W-1:0]     abus,
    output logic                 ale,
    output logic                 strobe,
    output logic                 write_o
);

    localparam int ADDR_W  = 3 * BUS_W;
    localparam int UPPER_W = 2 * BUS_W;
    localparam int MAX_CYC = (STEP_CYC > STROBE_CYC) ? STEP_CYC : STROBE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_t        state;
    logic              accept;
    logic              restart;
    logic              page_hit;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  addr_byte [3];

    // Split the held address into bus-wide bytes
    for (genvar k = 0; k < 3; k++) begin : g_byte
        assign addr_byte[k] = addr_q[k*BUS_W +: BUS_W];
    end

    page_tracker #(.UPPER_W(UPPER_W)) tracker_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && !page_hit),
        .upper_in (req_addr[ADDR_W-1:BUS_W]),
        .hit      (page_hit)
    );

    step_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count   (count)
    );

    seq_fsm #(
        .ADDR_W     (ADDR_W),
        .STEP_CYC   (STEP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .CNT_W      (CNT_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .page_hit  (page_hit),
        .count     (count),
        .accept    (accept),
        .restart   (restart),
        .state     (state),
        .addr_q    (addr_q),
        .write_q   (write_o),
        .done      (done)
    );

    // Select the byte on the shared bus for the current phase
    always_comb begin
        unique case (state)
            ST_HI, ST_CLE_UP:  abus = addr_byte[2];
            ST_MID, ST_CLE_DN: abus = addr_byte[1];
            default:           abus = addr_byte[0];
        endcase
    end

    // Decode control line, strobe and ready from the phase
    always_comb begin
        ale       = (state == ST_CLE_UP) || (state == ST_MID);
        strobe    = (state == ST_STROBE);
        req_ready = (state == ST_IDLE);
    end

endmodule

// File: rtl/addr_expand_seq_chk.sv
// Module: addr_expand_seq_chk
// Temporal checks on the sequencer pins, bound into every instance.
// Assumes: reset is asserted from time zero.
module addr_expand_seq_chk #(
    parameter int BUS_W      = 8,
    parameter int STROBE_CYC = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             done,
    input logic [BUS_W-1:0] abus,
    input logic             ale,
    input logic             strobe
);

    logic [31:0] strobe_run;

    // Length of the current strobe run, for the width check
    always_ff @(posedge clk) begin
        if (!rst_n)      strobe_run <= '0;
        else if (strobe) strobe_run <= strobe_run + 1;
        else             strobe_run <= '0;
    end

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!strobe && !ale));

    assert_ale_rise_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $stable(abus));

    assert_ale_fall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> $stable(abus));

    assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> (strobe_run == 32'(STROBE_CYC)));

    assert_strobe_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (strobe_run < 32'(STROBE_CYC)));

    assert_strobe_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> ($stable(abus) && !ale));

    assert_after_strobe_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> ($stable(abus) && !ale));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !strobe);

endmodule

bind addr_expand_seq addr_expand_seq_chk #(
    .BUS_W      (BUS_W),
    .STROBE_CYC (STROBE_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .abus      (abus),
    .ale       (ale),
    .strobe    (strobe)
);

// File: tb/addr_expand_seq_tb_top.sv
// Directed bench: behavioural latch and register rebuild the address from
// the pins; each scenario task checks its own results.
module addr_expand_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int STEP       = 2;
    localparam int STRB       = 3;
    localparam int FULL_LAT   = 6 * STEP + STRB;
    localparam int FAST_LAT   = 2 * STEP + STRB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_ready, done, ale, strobe, write_o;
    logic [7:0]  abus;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_expand_seq #(.BUS_W(8), .STEP_CYC(STEP), .STROBE_CYC(STRB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_ready(req_ready), .done(done),
        .abus(abus), .ale(ale), .strobe(strobe), .write_o(write_o)
    );

    // Board model: transparent latch for the middle byte, register for the top
    logic [7:0] lat_q = '0;
    logic [7:0] reg_q = '0;
    always_latch if (ale) lat_q <= abus;
    always @(posedge ale) reg_q <= abus;

    int ale_rises = 0;
    always @(posedge ale) ale_rises++;

    // Strobe monitor, sampled away from the clock edge
    logic [23:0] cap_addr = '0;
    logic        cap_wr = 1'b0;
    int strobe_count = 0, run = 0, last_run = 0, unstable = 0;
    logic strobe_prev = 1'b0;
    always @(negedge clk) begin
        if (strobe) begin
            if (!strobe_prev) begin
                cap_addr = {reg_q, lat_q, abus};
                cap_wr   = write_o;
                strobe_count++;
            end else if (abus != cap_addr[7:0] || ale) begin
                unstable++;
            end
            run++;
        end else if (strobe_prev) begin
            last_run = run;
            run = 0;
            if (abus != cap_addr[7:0] || ale) unstable++;
        end
        strobe_prev = strobe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One access: drive, measure latency, check address, flag, edges, widths
    task automatic do_access(input logic [23:0] a, input logic wr, input bit fast,
                             input string req);
        int n, s0, e0, u0;
        @(negedge clk);
        check(req_ready && !ale, "R3", {req_ready, ale}, 2'b10);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        s0 = strobe_count; e0 = ale_rises; u0 = unstable;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(n == (fast ? FAST_LAT : FULL_LAT), req, n, fast ? FAST_LAT : FULL_LAT);
        check(ale_rises - e0 == (fast ? 0 : 1), req, ale_rises - e0, fast ? 0 : 1);
        check(strobe_count - s0 == 1, "R8", strobe_count - s0, 1);
        check(cap_addr == a, "R2", cap_addr, a);
        check(cap_wr == wr, "R9", cap_wr, wr);
        check(last_run == STRB, "R6", last_run, STRB);
        check(unstable == u0, "R7", unstable - u0, 0);
        @(negedge clk);
        check(!done, "R9", done, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready, "R1", req_ready, 1);
        check(!ale && !strobe, "R1", {ale, strobe}, 0);
        check(!done, "R1", done, 0);
    endtask

    task automatic t_first_after_reset();
        do_access(24'h000000, 1'b0, 1'b0, "R1");   // empty page memory
    endtask

    task automatic t_same_page();
        do_access(24'h0000A7, 1'b1, 1'b1, "R4");
        do_access(24'h0000FF, 1'b0, 1'b1, "R4");
    endtask

    task automatic t_page_change();
        do_access(24'h000112, 1'b0, 1'b0, "R5");   // middle byte differs
        do_access(24'h010112, 1'b1, 1'b0, "R5");   // top byte differs
        do_access(24'hABCDEF, 1'b0, 1'b0, "R5");
        do_access(24'hABCD00, 1'b1, 1'b1, "R4");
        do_access(24'h7BCD00, 1'b0, 1'b0, "R5");
    endtask

    // A request held high while busy must not start a second access
    task automatic t_busy_ignore();
        int n, s0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'h123456; req_write = 1'b0;
        s0 = strobe_count;
        @(negedge clk);
        req_addr = 24'h654321;                     // still valid while busy
        n = 0;
        while (!done && n < 200) begin
            check(!req_ready, "R8", req_ready, 0);
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        check(strobe_count - s0 == 1, "R8", strobe_count - s0, 1);
        check(cap_addr == 24'h123456, "R8", cap_addr, 24'h123456);
        repeat (FULL_LAT) @(negedge clk);
        check(strobe_count - s0 == 1, "R8", strobe_count - s0, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_after_reset();
        t_same_page();
        t_page_change();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule